// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel LCD panel. It creates horizontal sync, vertical sync, data-enable, a pixel-rate clock enable and a pixel clock level. It also gives a per-line pulse and a per-frame pulse. All timing comes from three packed 32-bit configuration words, written through a simple word-select write port. The pixel rate is the logic clock divided by an integer. The divider has a lower limit that depends on the panel type: 2 for active-matrix (TFT) panels and 3 for passive panels.

Each line passes through four phases in a fixed order: sync, back porch, active pixels, front porch. Each frame passes through the same four phases, counted in lines. Data-enable is high only where the horizontal and the vertical active regions overlap. Configuration words are held in staging registers. They are copied into the working set only on the last pixel of a frame, so a frame in progress never changes its geometry. Polarity bits can invert either sync output and the pixel clock level.

Top module: `lcd_raster_timer`

## Requirements
- R1: While reset is held, pix_ce_o, de_o, line_o and frame_o are 0, and hsync_o and vsync_o are 1 (the reset configuration has no inversion and starts in the sync phase).
- R2: pix_ce_o pulses for one cycle every D cycles. D is the larger of word 2 bits 7:0 and the panel floor, where the floor is 2 when panel_tft is 1 and 3 when it is 0. The largest D is 255.
- R3: A line lasts A+S+B+F pixels. Word 0 holds A-1 in bits 9:0, S-1 in bits 15:10, F-1 in bits 23:16 and B-1 in bits 31:24. The sync phase covers the first S pixels of each line.
- R4: de_o is high only for pixels inside both active regions. The first such pixel is pixel S+B of line VS+VB, and each frame has A times VA of them.
- R5: A frame lasts VS+VB+VA+VF lines. Word 1 holds VA-1 in bits 9:0 and VS-1 in bits 15:10. VF sits in bits 23:16 and VB in bits 31:24, both as the actual count. Vertical sync covers the first VS lines.
- R6: line_o is a one-cycle pulse, coincident with pix_ce_o, on the last pixel of every line.
- R7: frame_o is a one-cycle pulse on the last pixel of the last line, coincident with line_o.
- R8: Word 2 bit 20 inverts vsync_o and bit 21 inverts hsync_o. de_o is never inverted.
- R9: cfg_sel values 0, 1 and 2 write words 0, 1 and 2 when cfg_we is 1, and a write with cfg_sel 3 changes nothing. Written words and panel_tft take effect only from the first pixel of the frame that follows.
- R10: pclk_o is high for the first floor(D/2) cycles of each pixel period and low for the rest. Word 2 bit 22 inverts it.
- R11: hsync_o, vsync_o and de_o change only at the clock edge that ends a pixel period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select (0..2; 3 ignored) |
| cfg_wdata | input | 32 | Configuration write data |
| panel_tft | input | 1 | 1 selects an active-matrix panel, 0 a passive panel |
| pix_ce_o | output | 1 | One-cycle pixel-rate enable |
| pclk_o | output | 1 | Pixel clock level |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| line_o | output | 1 | End-of-line pulse |
| frame_o | output | 1 | End-of-frame pulse |

## Verification
A wrong horizontal position shows up within one line as a changed count of pixels between line pulses, or a shifted first data-enable pixel. A vertical error needs a full frame before the line count or the vsync width comes out wrong. A bad divider or floor changes the cycle count of every pixel period at once. The pclk_o high time shows the divider's half-point inside a single pixel. Early use of a staged configuration word changes the frame in progress, so each new configuration is measured in both the frame during which it is written and the frame after it.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;
   localparam int LEN_W   = 12;
   localparam int N_WORDS = 3;

   typedef struct packed {
      logic [LEN_W-1:0] h_sync;
      logic [LEN_W-1:0] h_back;
      logic [LEN_W-1:0] h_act;
      logic [LEN_W-1:0] h_front;
      logic [LEN_W-1:0] v_sync;
      logic [LEN_W-1:0] v_back;
      logic [LEN_W-1:0] v_act;
      logic [LEN_W-1:0] v_front;
      logic [7:0]       div;
      logic             inv_v;
      logic             inv_h;
      logic             inv_p;
      logic             tft;
   } timing_t;

   function automatic timing_t unpack_timing(input logic [31:0] w0, input logic [31:0] w1,
                                             input logic [31:0] w2, input logic tft);
      timing_t t;
      t.h_act   = LEN_W'(w0[9:0])   + 1'b1;
      t.h_sync  = LEN_W'(w0[15:10]) + 1'b1;
      t.h_front = LEN_W'(w0[23:16]) + 1'b1;
      t.h_back  = LEN_W'(w0[31:24]) + 1'b1;
      t.v_act   = LEN_W'(w1[9:0])   + 1'b1;
      t.v_sync  = LEN_W'(w1[15:10]) + 1'b1;
      t.v_front = LEN_W'(w1[23:16]);
      t.v_back  = LEN_W'(w1[31:24]);
      t.div     = w2[7:0];
      t.inv_v   = w2[20];
      t.inv_h   = w2[21];
      t.inv_p   = w2[22];
      t.tft     = tft;
      return t;
   endfunction
endpackage

// File: rtl/lcd_rt_cfg.sv
module lcd_rt_cfg
   import lcd_rt_pkg::*;
#(
   parameter logic [31:0] DEF_W0  = 32'h0201_0407,
   parameter logic [31:0] DEF_W1  = 32'h0101_0403,
   parameter logic [31:0] DEF_W2  = 32'h0000_0002,
   parameter bit          DEF_TFT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [1:0]  sel,
   input  logic [31:0] wdata,
   input  logic        tft_in,
   input  logic        load,
   output timing_t     tm
);
   localparam logic [31:0] DEFS [N_WORDS] = '{DEF_W0, DEF_W1, DEF_W2};

   logic [31:0] stage_w [N_WORDS];
   logic [31:0] live_w  [N_WORDS];
   logic        live_tft;

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_w[i] <= DEFS[i];
            live_w[i]  <= DEFS[i];
         end else begin
            if (we && (sel == 2'(i))) stage_w[i] <= wdata;
            if (load)                 live_w[i]  <= stage_w[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    live_tft <= DEF_TFT;
      else if (load) live_tft <= tft_in;
   end

   assign tm = unpack_timing(live_w[0], live_w[1], live_w[2], live_tft);

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{live_w[2][19:8], live_w[2][31:23]};
endmodule

// File: rtl/lcd_rt_pixdiv.sv
module lcd_rt_pixdiv #(
   parameter int DIV_W     = 8,
   parameter int FLOOR_TFT = 2,
   parameter int FLOOR_STN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_field,
   input  logic             tft,
   input  logic             inv_p,
   output logic             ce,
   output logic             pclk
);
   localparam logic [DIV_W-1:0] FL_TFT = DIV_W'(FLOOR_TFT);
   localparam logic [DIV_W-1:0] FL_STN = DIV_W'(FLOOR_STN);

   if (FLOOR_TFT < 2 || FLOOR_STN < 2 || FLOOR_TFT >= (1 << DIV_W) || FLOOR_STN >= (1 << DIV_W)) begin : g_bad_floor
      $error("pixel divider floors must lie in 2 .. 2**DIV_W-1");
   end

   logic [DIV_W-1:0] floor_v, d_eff, cnt;

   assign floor_v = tft ? FL_TFT : FL_STN;
   assign d_eff   = (div_field < floor_v) ? floor_v : div_field;
   assign ce      = (cnt == d_eff - 1'b1);
   assign pclk    = (cnt < (d_eff >> 1)) ^ inv_p;

   always_ff @(posedge clk) begin
      if (!rst_n)  cnt <= '0;
      else if (ce) cnt <= '0;
      else         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lcd_rt_axis.sv
module lcd_rt_axis #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] sync_len,
   input  logic [CNT_W-1:0] back_len,
   input  logic [CNT_W-1:0] act_len,
   input  logic [CNT_W-1:0] front_len,
   output logic             in_sync,
   output logic             in_act,
   output logic             last
);
   logic [CNT_W-1:0] pos, act_start, act_stop, total;

   assign act_start = sync_len + back_len;
   assign act_stop  = act_start + act_len;
   assign total     = act_stop + front_len;
   assign last      = (pos == total - 1'b1);
   assign in_sync   = (pos < sync_len);
   assign in_act    = (pos >= act_start) && (pos < act_stop);

   always_ff @(posedge clk) begin
      if (!rst_n)    pos <= '0;
      else if (step) pos <= last ? '0 : pos + 1'b1;
   end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lcd_rt_pkg::*;
#(
   parameter int          CNT_W     = 12,
   parameter int          FLOOR_TFT = 2,
   parameter int          FLOOR_STN = 3,
   parameter logic [31:0] DEF_W0    = 32'h0201_0407,
   parameter logic [31:0] DEF_W1    = 32'h0101_0403,
   parameter logic [31:0] DEF_W2    = 32'h0000_0002,
   parameter bit          DEF_TFT   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        panel_tft,
   output logic        pix_ce_o,
   output logic        pclk_o,
   output logic        hsync_o,
   output logic        vsync_o,
   output logic        de_o,
   output logic        line_o,
   output logic        frame_o
);
   localparam int MIN_CNT_W = 11;

   if (CNT_W < MIN_CNT_W || CNT_W > LEN_W) begin : g_bad_width
      $error("CNT_W must hold the longest line of 1600 pixels and fit the field width");
   end

   timing_t tm;
   logic    frame_end;
   logic    h_sync, h_act, h_last;
   logic    v_sync, v_act, v_last;

   lcd_rt_cfg #(
      .DEF_W0(DEF_W0), .DEF_W1(DEF_W1), .DEF_W2(DEF_W2), .DEF_TFT(DEF_TFT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .tft_in(panel_tft), .load(frame_end), .tm(tm)
   );

   lcd_rt_pixdiv #(
      .DIV_W(8), .FLOOR_TFT(FLOOR_TFT), .FLOOR_STN(FLOOR_STN)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .div_field(tm.div), .tft(tm.tft), .inv_p(tm.inv_p),
      .ce(pix_ce_o), .pclk(pclk_o)
   );

   lcd_rt_axis #(.CNT_W(CNT_W)) u_h (
      .clk(clk), .rst_n(rst_n), .step(pix_ce_o),
      .sync_len(CNT_W'(tm.h_sync)), .back_len(CNT_W'(tm.h_back)),
      .act_len(CNT_W'(tm.h_act)), .front_len(CNT_W'(tm.h_front)),
      .in_sync(h_sync), .in_act(h_act), .last(h_last)
   );

   lcd_rt_axis #(.CNT_W(CNT_W)) u_v (
      .clk(clk), .rst_n(rst_n), .step(line_o),
      .sync_len(CNT_W'(tm.v_sync)), .back_len(CNT_W'(tm.v_back)),
      .act_len(CNT_W'(tm.v_act)), .front_len(CNT_W'(tm.v_front)),
      .in_sync(v_sync), .in_act(v_act), .last(v_last)
   );

   assign line_o    = pix_ce_o & h_last;
   assign frame_end = line_o & v_last;
   assign frame_o   = frame_end;
   assign de_o      = h_act & v_act;
   assign hsync_o   = h_sync ^ tm.inv_h;
   assign vsync_o   = v_sync ^ tm.inv_v;
endmodule

// File: rtl/lcd_rt_chk.sv
module lcd_rt_chk (
   input logic clk,
   input logic rst_n,
   input logic pix_ce,
   input logic line_p,
   input logic frame_p,
   input logic hsync,
   input logic vsync,
   input logic de,
   input logic h_in_sync
);
   assert_ce_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ce |=> !pix_ce);

   assert_line_on_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
      line_p |-> pix_ce);

   assert_frame_with_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_p |-> line_p);

   assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !h_in_sync);

   assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pix_ce) |-> ($stable(hsync) && $stable(vsync) && $stable(de)));
endmodule

bind lcd_raster_timer lcd_rt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce_o), .line_p(line_o), .frame_p(frame_o),
   .hsync(hsync_o), .vsync(vsync_o), .de(de_o), .h_in_sync(h_sync)
);

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;
   localparam int CLK_P = 10;

   typedef struct packed {
      int ppl; int hsw; int hfp; int hbp;
      int lpf; int vsw; int vfp; int vbp;
      int div; int pol; int tft;
   } vec_t;

   typedef struct packed {
      int cyc; int pix; int hs; int vs; int de; int lines; int fde; int pch;
   } res_t;

   localparam int NV = 4;
   localparam vec_t VECS [NV] = '{
      '{7, 1, 1, 2, 3, 1, 1, 1,   2, 0, 1},
      '{3, 0, 0, 0, 1, 0, 0, 0,   1, 7, 0},
      '{4, 2, 3, 0, 2, 1, 2, 3,   0, 2, 1},
      '{1, 0, 0, 0, 0, 0, 0, 0, 255, 0, 1}
   };

   logic clk = 0, rst_n = 0, cfg_we = 0, panel_tft = 1;
   logic [1:0]  cfg_sel = 0;
   logic [31:0] cfg_wdata = 0;
   logic pix_ce_o, pclk_o, hsync_o, vsync_o, de_o, line_o, frame_o;

   int nchk = 0, nfail = 0;
   int m_hs0, m_vs0, m_fwl, m_unst;

   always #(CLK_P/2) clk = ~clk;

   lcd_raster_timer u_lcd_raster_timer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .panel_tft(panel_tft), .pix_ce_o(pix_ce_o), .pclk_o(pclk_o), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .de_o(de_o), .line_o(line_o), .frame_o(frame_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic res_t expect_of(vec_t v);
      res_t e;
      int fl, d, h, nl;
      fl = v.tft ? 2 : 3;
      d  = (v.div < fl) ? fl : v.div;
      h  = (v.ppl + 1) + (v.hsw + 1) + (v.hfp + 1) + (v.hbp + 1);
      nl = (v.vsw + 1) + v.vbp + (v.lpf + 1) + v.vfp;
      e.cyc = h * nl * d;  e.pix = h * nl;
      e.hs = (v.hsw + 1) * nl;  e.vs = (v.vsw + 1) * h;
      e.de = (v.ppl + 1) * (v.lpf + 1);  e.lines = nl;
      e.fde = (v.vsw + 1 + v.vbp) * h + (v.hsw + 1) + (v.hbp + 1);
      e.pch = h * nl * (d / 2);
      return e;
   endfunction

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic load_vec(input vec_t v);
      panel_tft = v.tft[0];
      wr(2'd0, {v.hbp[7:0], v.hfp[7:0], v.hsw[5:0], v.ppl[9:0]});
      wr(2'd1, {v.vbp[7:0], v.vfp[7:0], v.vsw[5:0], v.lpf[9:0]});
      wr(2'd2, (32'(v.pol) << 20) | 32'(v.div));
   endtask

   task automatic wait_frame();
      do @(negedge clk); while (!frame_o);
   endtask

   // counts one full frame, starting right after a frame pulse
   task automatic measure(input int pol, output res_t r);
      bit done = 0, first = 1, prev_ce = 1;
      logic ph = 0, pv = 0, pd = 0;
      r = '0; r.fde = -1;
      m_fwl = 0; m_unst = 0;
      while (!done) begin
         @(negedge clk);
         if (first) begin m_hs0 = hsync_o; m_vs0 = vsync_o; first = 0; end
         else if (!prev_ce && (hsync_o != ph || vsync_o != pv || de_o != pd)) m_unst++;
         ph = hsync_o; pv = vsync_o; pd = de_o; prev_ce = pix_ce_o;
         r.cyc++;
         if (pclk_o ^ pol[2]) r.pch++;
         if (pix_ce_o) begin
            if (de_o && r.fde < 0) r.fde = r.pix;
            r.pix++;
            if (hsync_o ^ pol[1]) r.hs++;
            if (vsync_o ^ pol[0]) r.vs++;
            if (de_o) r.de++;
            if (line_o) r.lines++;
            if (frame_o) begin done = 1; m_fwl = line_o; end
         end
      end
   endtask

   task automatic compare(input string tag, input res_t a, input res_t e);
      chk("R2",  {tag, " cycles per frame"}, a.cyc, e.cyc);
      chk("R3",  {tag, " pixels per frame"}, a.pix, e.pix);
      chk("R3",  {tag, " hsync pixels"},     a.hs,  e.hs);
      chk("R5",  {tag, " vsync pixels"},     a.vs,  e.vs);
      chk("R4",  {tag, " de pixels"},        a.de,  e.de);
      chk("R6",  {tag, " line pulses"},      a.lines, e.lines);
      chk("R4",  {tag, " first de pixel"},   a.fde, e.fde);
      chk("R10", {tag, " pclk high cycles"}, a.pch, e.pch);
      chk("R7",  {tag, " frame with line"},  m_fwl, 1);
      chk("R11", {tag, " mid-pixel changes"}, m_unst, 0);
   endtask

   initial begin
      #(CLK_P * 190000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      res_t r;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", "pix_ce in reset", pix_ce_o, 0);
      chk("R1", "de in reset",     de_o, 0);
      chk("R1", "line in reset",   line_o, 0);
      chk("R1", "frame in reset",  frame_o, 0);
      chk("R1", "hsync in reset",  hsync_o, 1);
      chk("R1", "vsync in reset",  vsync_o, 1);
      rst_n = 1;

      for (int i = 0; i < NV; i++) begin
         load_vec(VECS[i]);
         wait_frame();
         measure(VECS[i].pol, r);
         compare($sformatf("vec%0d", i), r, expect_of(VECS[i]));
         chk("R8", $sformatf("vec%0d hsync level in sync", i), m_hs0, 1 ^ VECS[i].pol[1]);
         chk("R8", $sformatf("vec%0d vsync level in sync", i), m_vs0, 1 ^ VECS[i].pol[0]);
      end

      // R9: words written during a frame leave that frame unchanged
      fork
         load_vec(VECS[1]);
         measure(VECS[3].pol, r);
      join
      compare("R9 old frame", r, expect_of(VECS[3]));
      measure(VECS[1].pol, r);
      compare("R9 new frame", r, expect_of(VECS[1]));

      // R9: select 3 writes are ignored
      fork
         wr(2'd3, 32'hFFFF_FFFF);
         measure(VECS[1].pol, r);
      join
      measure(VECS[1].pol, r);
      chk("R9", "sel3 cycles", r.cyc, expect_of(VECS[1]).cyc);
      chk("R9", "sel3 pixels", r.pix, expect_of(VECS[1]).pix);
      chk("R9", "sel3 pclk",   r.pch, expect_of(VECS[1]).pch);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule